// File: doc/BRIEF.md
# Global Memory Bus Request Arbiter

This block sits on the processor side of a shared data bus. It decides whether each data operand access lands in a global memory window that other processors also use. For an access inside the window, it asks for the shared bus and makes the access last until the bus grants a ready indication. An 8-bit allocation register, loaded through its own write port, sets how much of the upper data address space counts as global. Each bit of that register selects one of the eight most significant address bits.

An access is offered on `acc_valid` together with `acc_addr` and `acc_wr`. The requester keeps these inputs steady until `acc_done` pulses. A local access finishes in the cycle it is offered. A global access raises `bus_req` in its first cycle. It completes in the first cycle in which `bus_ready` is sampled high, which may be that same first cycle.

The control FSM has two states. `ST_IDLE` means no global cycle is outstanding. `ST_GWAIT` means a global cycle is waiting for ready. The FSM has three transitions:
- IDLE->GWAIT: a global access arrives while `bus_ready` is low.
- GWAIT->GWAIT: `bus_ready` is still low.
- GWAIT->IDLE: `bus_ready` is high.

In IDLE, a local access, or a global access that sees ready at once, completes without leaving IDLE.

Top module: `gmem_bus_req`

## Requirements
- R1: Reset clears the allocation register to 0x00. Until it is written, every access is local, including address 0xFFFF.
- R2: A write on `cfg_we` loads `cfg_wdata` at the clock edge. An access offered in the same cycle as the write is classified with the old value. Accesses in later cycles use the new value.
- R3: Allocation bit k (k = 0..7) selects address bit 8+k. An address is global when every address bit selected by a set allocation bit is 1, and at least one allocation bit is set.
- R4: A local access never asserts `bus_req`. It pulses `acc_done` in the same cycle that `acc_valid` is first seen.
- R5: A global access asserts `bus_req` from its first cycle. `bus_req` stays high through every cycle with `bus_ready` low. `acc_done` pulses in the first cycle with `bus_ready` high, and `bus_req` is low in the next cycle unless a new global access starts then.
- R6: With no access offered and none outstanding, `bus_req` and `acc_done` stay low, whatever `bus_ready` does.
- R7: An allocation register write made while a global cycle is outstanding does not end or alter that cycle.
- R8: An allocation value of 0x00 means no global space, for every address.
- R9: `gbl_wr` equals the `acc_wr` value of the global access while `bus_req` is high, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Allocation register write strobe |
| cfg_wdata | input | 8 | Allocation register write value |
| acc_valid | input | 1 | Data access offered; held until acc_done |
| acc_addr | input | 16 | Data access address |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| bus_ready | input | 1 | Shared bus ready for the global cycle |
| bus_req | output | 1 | Request for the shared bus |
| gbl_wr | output | 1 | Direction of the global cycle in progress |
| acc_done | output | 1 | One-cycle pulse ending an access |

## Verification
The assertions assume that the requester keeps `acc_valid`, `acc_addr` and `acc_wr` steady from the first cycle of an access until the cycle in which `acc_done` pulses. They also assume that `bus_ready` is only meaningful while a global cycle is outstanding. The stimulus drives every access as a held request and changes its inputs only after the done pulse. It raises `bus_ready` both inside and outside global cycles, and it writes the allocation register only in cycles where these assumptions still hold.

// File: rtl/gmb_pkg.sv
package gmb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GWAIT = 1'b1
    } gmb_state_e;
endpackage

// File: rtl/gmb_alloc_reg.sv
module gmb_alloc_reg #(
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wr_data,
    output logic [MASK_W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_data;
        end
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_q == $past(wr_data)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(mask_q));
endmodule

// File: rtl/gmb_region_cmp.sv
module gmb_region_cmp #(
    parameter int ADDR_W = 16,
    parameter int MASK_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    localparam int LOW_W = ADDR_W - MASK_W;

    logic [ADDR_W-1:0] mask_ext;
    logic [ADDR_W-1:0] bit_ok;

    assign mask_ext = {mask, {LOW_W{1'b0}}};

    genvar g;
    generate
        for (g = 0; g < ADDR_W; g++) begin : g_bit
            assign bit_ok[g] = addr[g] | ~mask_ext[g];
        end
    endgenerate

    assign hit = (|mask) & (&bit_ok);

    // R8
    always_comb begin
        empty_chk: assert (!(hit && (mask == '0)));
    end
endmodule

// File: rtl/gmb_ctrl_fsm.sv
module gmb_ctrl_fsm
    import gmb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  logic acc_wr,
    input  logic hit,
    input  logic bus_ready,
    output logic bus_req,
    output logic gbl_wr,
    output logic acc_done
);
    gmb_state_e state_q, state_d;
    logic       wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
        end else if (state_q == ST_IDLE && acc_valid && hit) begin
            wr_q <= acc_wr;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_valid && hit && !bus_ready) begin
                    state_d = ST_GWAIT;
                end
            end
            ST_GWAIT: begin
                if (bus_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req  = 1'b0;
        gbl_wr   = 1'b0;
        acc_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_valid) begin
                    if (hit) begin
                        bus_req  = 1'b1;
                        gbl_wr   = acc_wr;
                        acc_done = bus_ready;
                    end else begin
                        acc_done = 1'b1;
                    end
                end
            end
            ST_GWAIT: begin
                bus_req  = 1'b1;
                gbl_wr   = wr_q;
                acc_done = bus_ready;
            end
            default: ;
        endcase
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> bus_req);

    // R5
    done_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready) |-> acc_done);

    // R4
    local_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && !bus_req) |-> acc_valid);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !acc_valid) |-> (!bus_req && !acc_done));

    // R9
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> $stable(gbl_wr));

    // R9
    wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> !gbl_wr);
endmodule

// File: rtl/gmem_bus_req.sv
module gmem_bus_req #(
    parameter int ADDR_W = 16,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MASK_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic              bus_ready,
    output logic              bus_req,
    output logic              gbl_wr,
    output logic              acc_done
);
    logic [MASK_W-1:0] mask_q;
    logic              hit;

    gmb_alloc_reg #(.MASK_W(MASK_W)) i_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .mask_q  (mask_q)
    );

    gmb_region_cmp #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) i_cmp (
        .addr (acc_addr),
        .mask (mask_q),
        .hit  (hit)
    );

    gmb_ctrl_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_wr    (acc_wr),
        .hit       (hit),
        .bus_ready (bus_ready),
        .bus_req   (bus_req),
        .gbl_wr    (gbl_wr),
        .acc_done  (acc_done)
    );
endmodule

// File: tb/test_gmem_bus_req.sv
module test_gmem_bus_req;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic        bus_ready = 1'b0;
    logic        bus_req, gbl_wr, acc_done;

    int tests = 0;
    int fails = 0;

    // reference model state
    logic [7:0] m_mask = 8'h00;
    bit         m_busy = 0;
    bit         m_wr = 0;

    always #2 clk = ~clk;

    gmem_bus_req i_gmem_bus_req (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .bus_ready(bus_ready), .bus_req(bus_req), .gbl_wr(gbl_wr),
        .acc_done(acc_done)
    );

    function automatic bit is_global(logic [7:0] m, logic [15:0] a);
        int sel = 0;
        int ones = 0;
        for (int k = 0; k < 8; k++) begin
            if (m[k]) begin
                sel++;
                if (a[8+k]) ones++;
            end
        end
        return (sel > 0) && (sel == ones);
    endfunction

    task automatic cmp(string req, string what, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(bit v, logic [15:0] a, bit w, bit rdy, bit we, logic [7:0] wd, string req);
        bit e_req, e_done, e_wr, n_busy, n_wr;
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_wr = w; bus_ready = rdy;
        cfg_we = we; cfg_wdata = wd;
        e_req = 0; e_done = 0; e_wr = 0; n_busy = m_busy; n_wr = m_wr;
        if (m_busy) begin
            e_req = 1; e_wr = m_wr; e_done = rdy; n_busy = !rdy;
        end else if (v) begin
            if (is_global(m_mask, a)) begin
                e_req = 1; e_wr = w; e_done = rdy; n_busy = !rdy; n_wr = w;
            end else begin
                e_done = 1;
            end
        end
        #1;
        cmp(req, "bus_req", bus_req, e_req);
        cmp(req, "acc_done", acc_done, e_done);
        cmp(req, "gbl_wr", gbl_wr, e_wr);
        m_busy = n_busy;
        m_wr = n_wr;
        if (we) m_mask = wd;
    endtask

    task automatic idle(int n, bit rdy, string req);
        for (int i = 0; i < n; i++) step(0, 16'h0000, 0, rdy, 0, 8'h00, req);
    endtask

    task automatic wr_cfg(logic [7:0] d, string req);
        step(0, 16'h0000, 0, 0, 1, d, req);
    endtask

    // global access held for nwait cycles of ready low, then ready high
    task automatic gacc(logic [15:0] a, bit w, int nwait, string req);
        for (int i = 0; i < nwait; i++) step(1, a, w, 0, 0, 8'h00, req);
        step(1, a, w, 1, 0, 8'h00, req);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: outputs quiet in reset
        repeat (3) @(posedge clk);
        #1;
        cmp("R1", "bus_req", bus_req, 1'b0);
        cmp("R1", "acc_done", acc_done, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, 1, "R6");
        // R1: reset mask is zero, top address is local
        step(1, 16'hFFFF, 0, 0, 0, 8'h00, "R1");
        idle(1, 0, "R6");
        // R3: mask F0
        wr_cfg(8'hF0, "R2");
        gacc(16'hF123, 1, 2, "R5");
        idle(1, 0, "R5");
        step(1, 16'hE000, 0, 0, 0, 8'h00, "R3");
        step(1, 16'h7FFF, 0, 0, 0, 8'h00, "R3");
        gacc(16'hF000, 0, 1, "R9");
        // R5: ready already high
        gacc(16'hFF00, 1, 0, "R5");
        // back-to-back global accesses
        gacc(16'hF800, 0, 3, "R5");
        gacc(16'hF400, 1, 1, "R9");
        // R3: sparse mask
        wr_cfg(8'h81, "R2");
        gacc(16'h8100, 0, 1, "R3");
        step(1, 16'h8000, 0, 0, 0, 8'h00, "R3");
        step(1, 16'h0100, 0, 0, 0, 8'h00, "R3");
        gacc(16'hBDFF, 1, 0, "R3");
        // R7: write during outstanding global cycle
        step(1, 16'h8100, 1, 0, 0, 8'h00, "R7");
        step(1, 16'h8100, 1, 0, 1, 8'h00, "R7");
        step(1, 16'h8100, 1, 0, 0, 8'h00, "R7");
        step(1, 16'h8100, 1, 1, 0, 8'h00, "R7");
        // R8: mask zero now
        step(1, 16'hFFFF, 1, 0, 0, 8'h00, "R8");
        step(1, 16'h8100, 0, 0, 0, 8'h00, "R8");
        // R2: same-cycle write uses old value
        step(1, 16'hFFFF, 0, 0, 1, 8'hFF, "R2");
        gacc(16'hFFFF, 0, 2, "R2");
        step(1, 16'hFEFF, 0, 1, 0, 8'h00, "R3");
        // R6: ready toggles with nothing outstanding
        idle(3, 1, "R6");
        step(0, 16'hFFFF, 1, 0, 0, 8'h00, "R6");
        step(0, 16'hFFFF, 1, 1, 0, 8'h00, "R6");
        // R4: local with mask 0x01
        wr_cfg(8'h01, "R2");
        step(1, 16'h0000, 1, 1, 0, 8'h00, "R4");
        gacc(16'h0100, 1, 2, "R9");
        idle(2, 0, "R6");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule